// File: doc/BRIEF.md
# Widening Lane Shift-Left Unit

The unit takes a 128-bit source vector and one 7-bit shift immediate. It picks one 64-bit half of the source. It splits that half into equal lanes and doubles the width of each lane, either by sign extension or by zero extension. It then shifts every widened lane left by the same amount and packs the lanes into a full 128-bit result. The 4-bit high part of the immediate sets the lane width through its leading one. The whole immediate, minus that lane width, gives the shift amount.

The block has one register stage. A request is presented with `in_valid`. The whole source, the control bits and the immediate are taken together at one clock edge, so an input lane is never read after any output lane has been produced. A caller can therefore write the result back over the register that supplied the source. The result and an invalid-encoding flag appear one cycle later with `out_valid`. An immediate with no usable lane width is reported through the flag, and the result is then zero.

Top module: `shl_long_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `bad_enc` and `wide_res` become 0 at that edge.
- R2: `out_valid` is high in the cycle after `in_valid` was high at a clock edge, and low in the cycle after `in_valid` was low.
- R3: The lane width follows the leading one of `imm_code[6:3]`. Pattern 0001 gives 8-bit lanes, 001x gives 16-bit lanes and 01xx gives 32-bit lanes. The shift equals `imm_code` minus that lane width, so it runs from 0 to width-1.
- R4: When `imm_code[6]` is 1 (64-bit lanes) or `imm_code[6:3]` is 0000, the encoding is invalid. The unit then returns `bad_enc`=1 and `wide_res`=0. Every other code returns `bad_enc`=0.
- R5: `hi_half`=0 selects `src_vec[63:0]`. `hi_half`=1 selects `src_vec[127:64]`.
- R6: When `zext`=1, each lane is zero-extended to twice its width.
- R7: When `zext`=0, each lane is sign-extended to twice its width using its top bit.
- R8: Source lane i starts at bit i*E of the selected half, where E is the lane width. After widening and shifting, it lands at bit i*2E of `wide_res`. Bits shifted past 2E are lost.
- R9: A shift of zero gives a plain lengthening move.
- R10: When `in_valid` is low at an edge, `wide_res` and `bad_enc` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| src_vec | input | 128 | Source vector |
| hi_half | input | 1 | Selects the upper 64-bit half when set |
| zext | input | 1 | Zero extension when set, sign extension when clear |
| imm_code | input | 7 | Width code in bits 6:3, plus shift bits |
| out_valid | output | 1 | Result valid, one cycle after the request |
| wide_res | output | 128 | Widened and shifted result |
| bad_enc | output | 1 | Immediate has no legal lane width |

## Verification
The checker does not check the data field by field. It assumes that `rst` is held for at least one edge before the first request, and it relies on each request being a single-cycle pulse of `in_valid` carrying stable data. The stimulus drives every input on the falling edge. It asserts reset for several cycles before any request. It then uses only the seven immediate bits, so every code is either one of the three legal widths or one of the invalid groups that the flag rules describe.

// File: rtl/shl_pkg.sv
package shl_pkg;

    localparam int IMM_W  = 7;
    localparam int AMT_W  = 5;
    localparam int NUM_SZ = 3;

    typedef enum logic [1:0] {
        LANE_B   = 2'd0,
        LANE_H   = 2'd1,
        LANE_W   = 2'd2,
        LANE_BAD = 2'd3
    } lane_sz_e;

    typedef struct packed {
        lane_sz_e           sz;
        logic [AMT_W-1:0]   amt;
        logic               bad;
    } shl_ctl_t;

    // Leading one of the high nibble picks the lane width; the remaining
    // low bits are the immediate minus that width.
    function automatic shl_ctl_t decode_imm(input logic [IMM_W-1:0] imm);
        shl_ctl_t c;
        c.sz  = LANE_BAD;
        c.amt = '0;
        c.bad = 1'b1;
        casez (imm[6:3])
            4'b01??: begin
                c.sz  = LANE_W;
                c.amt = imm[4:0];
                c.bad = 1'b0;
            end
            4'b001?: begin
                c.sz  = LANE_H;
                c.amt = {1'b0, imm[3:0]};
                c.bad = 1'b0;
            end
            4'b0001: begin
                c.sz  = LANE_B;
                c.amt = {2'b00, imm[2:0]};
                c.bad = 1'b0;
            end
            default: begin
                c.sz  = LANE_BAD;
                c.amt = '0;
                c.bad = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/shl_decode.sv
module shl_decode
    import shl_pkg::*;
(
    input  logic [IMM_W-1:0] imm,
    output shl_ctl_t         ctl
);

    always_comb begin
        ctl = decode_imm(imm);
    end

endmodule

// File: rtl/shl_widen_lanes.sv
module shl_widen_lanes #(
    parameter int HALF_W = 64,
    parameter int ES     = 8
) (
    input  logic [HALF_W-1:0]      half,
    input  logic                   zext,
    input  logic [$clog2(ES)-1:0]  amt,
    output logic [2*HALF_W-1:0]    wide
);

    localparam int NL = HALF_W / ES;
    localparam int WE = 2 * ES;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [ES-1:0] lane;
        logic          fill;
        logic [WE-1:0] ext;
        assign lane = half[i*ES +: ES];
        assign fill = ~zext & lane[ES-1];
        assign ext  = {{ES{fill}}, lane};
        assign wide[i*WE +: WE] = ext << amt;
    end

endmodule

// File: rtl/shl_out_stage.sv
module shl_out_stage #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         bad_in,
    input  logic [W-1:0] data_in,
    output logic         out_valid,
    output logic         bad_out,
    output logic [W-1:0] data_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            bad_out   <= 1'b0;
            data_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                bad_out  <= bad_in;
                data_out <= bad_in ? '0 : data_in;
            end
        end
    end

endmodule

// File: rtl/shl_long_unit.sv
module shl_long_unit
    import shl_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2*HALF_W-1:0] src_vec,
    input  logic                hi_half,
    input  logic                zext,
    input  logic [IMM_W-1:0]    imm_code,
    output logic                out_valid,
    output logic [2*HALF_W-1:0] wide_res,
    output logic                bad_enc
);

    localparam int OUT_W = 2 * HALF_W;

    shl_ctl_t          ctl;
    logic [HALF_W-1:0] half;
    logic [OUT_W-1:0]  cand [NUM_SZ];
    logic [OUT_W-1:0]  sel;

    shl_decode u_dec (
        .imm (imm_code),
        .ctl (ctl)
    );

    assign half = hi_half ? src_vec[OUT_W-1:HALF_W] : src_vec[HALF_W-1:0];

    // One widening datapath per legal lane width.
    for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
        localparam int ES = 8 << k;
        localparam int AW = $clog2(ES);
        shl_widen_lanes #(
            .HALF_W (HALF_W),
            .ES     (ES)
        ) u_widen (
            .half (half),
            .zext (zext),
            .amt  (ctl.amt[AW-1:0]),
            .wide (cand[k])
        );
    end

    always_comb begin
        case (ctl.sz)
            LANE_B:  sel = cand[0];
            LANE_H:  sel = cand[1];
            LANE_W:  sel = cand[2];
            default: sel = '0;
        endcase
    end

    shl_out_stage #(
        .W (OUT_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .bad_in    (ctl.bad),
        .data_in   (sel),
        .out_valid (out_valid),
        .bad_out   (bad_enc),
        .data_out  (wide_res)
    );

endmodule

// File: rtl/shl_long_chk.sv
module shl_long_chk #(
    parameter int HALF_W = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [6:0]          imm_code,
    input logic                out_valid,
    input logic [2*HALF_W-1:0] wide_res,
    input logic                bad_enc
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !bad_enc && wide_res == '0));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4
    bad_code_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (imm_code[6] || imm_code[6:3] == 4'b0000)) |=> bad_enc);

    // R4
    good_code_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !imm_code[6] && imm_code[6:3] != 4'b0000) |=> !bad_enc);

    // R4
    bad_zero_res_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && bad_enc) |-> wide_res == '0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(wide_res) && $stable(bad_enc)));

endmodule

bind shl_long_unit shl_long_chk #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .imm_code  (imm_code),
    .out_valid (out_valid),
    .wide_res  (wide_res),
    .bad_enc   (bad_enc)
);

// File: tb/sim_shl_long_unit.sv
`timescale 1ns/1ps
module sim_shl_long_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] src_vec;
    logic         hi_half;
    logic         zext;
    logic [6:0]   imm_code;
    logic         out_valid;
    logic [127:0] wide_res;
    logic         bad_enc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    shl_long_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_vec   (src_vec),
        .hi_half   (hi_half),
        .zext      (zext),
        .imm_code  (imm_code),
        .out_valid (out_valid),
        .wide_res  (wide_res),
        .bad_enc   (bad_enc)
    );

    typedef struct packed {
        logic [127:0] src;
        logic         q;
        logic         u;
        logic [6:0]   imm;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0, 1'b1, 7'd8},  // R9 R6 8-bit
        '{128'h0123456789ABCDEF_FEDCBA9876543210, 1'b1, 1'b0, 7'd8},  // R5 R7
        '{128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0, 1'b0, 7'd15}, // R8 top shift
        '{128'h80017FFF0000FFFF_1234567890ABCDEF, 1'b1, 1'b1, 7'd16}, // R3 16-bit
        '{128'h80017FFF0000FFFF_8001F00F00FF7FFF, 1'b0, 1'b0, 7'd23}, // R7 R8
        '{128'h80017FFF0000FFFF_1234567890ABCDEF, 1'b1, 1'b0, 7'd31}, // R8 shift 15
        '{128'hDEADBEEF80000000_CAFEF00D7FFFFFFF, 1'b0, 1'b1, 7'd32}, // R9 32-bit
        '{128'hDEADBEEF80000000_CAFEF00D7FFFFFFF, 1'b1, 1'b0, 7'd63}, // R8 shift 31
        '{{128{1'b1}},                              1'b0, 1'b0, 7'd13}, // R7 all ones
        '{128'h0000000080000000_8000000000000001, 1'b0, 1'b0, 7'd40}, // R3 R7
        '{128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0, 1'b1, 7'd64}, // R4 64-bit
        '{128'h0123456789ABCDEF_FEDCBA9876543210, 1'b1, 1'b0, 7'd0},  // R4 empty code
        '{128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0, 1'b1, 7'd7}   // R4 empty code
    };

    // Expected result built bit by bit from the requirements.
    function automatic void model(input vec_t v, output logic bad, output logic [127:0] res);
        int es;
        int sh;
        logic [63:0] hf;
        res = '0;
        bad = 1'b0;
        if (v.imm[6] || v.imm[6:3] == 4'b0000) begin
            bad = 1'b1;
            return;
        end
        es = v.imm[5] ? 32 : (v.imm[4] ? 16 : 8);
        sh = int'(v.imm) - es;
        hf = v.q ? v.src[127:64] : v.src[63:0];
        for (int i = 0; i < 64 / es; i++) begin
            for (int b = 0; b < 2 * es; b++) begin
                int s;
                s = b - sh;
                if (s < 0)
                    res[i*2*es + b] = 1'b0;
                else if (s < es)
                    res[i*2*es + b] = hf[i*es + s];
                else
                    res[i*2*es + b] = v.u ? 1'b0 : hf[i*es + es - 1];
            end
        end
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        src_vec  = v.src;
        hi_half  = v.q;
        zext     = v.u;
        imm_code = v.imm;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        vec_t v;
        logic eb;
        logic [127:0] er;
        rst      = 1'b1;
        in_valid = 1'b0;
        src_vec  = '0;
        hi_half  = 1'b0;
        zext     = 1'b0;
        imm_code = '0;
        repeat (4) @(negedge clk);
        chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R1 bad_enc",   {127'd0, bad_enc},   128'd0);
        chk("R1 wide_res",  wide_res,            128'd0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk
        for (int n = 0; n < NV; n++) begin
            v = VECS[n];
            model(v, eb, er);
            issue(v);
            chk("R2 out_valid", {127'd0, out_valid}, 128'd1);
            chk(eb ? "R4 bad_enc" : "R3 bad_enc", {127'd0, bad_enc}, {127'd0, eb});
            chk(eb ? "R4 result" : "R8 result", wide_res, er);
        end

        // R7 hand value: 0x80 signed 8-bit lane -> 0xFF80
        issue('{128'h80, 1'b0, 1'b0, 7'd8});
        chk("R7 sign fill", wide_res, 128'hFF80);
        // R6 hand value: same lane unsigned -> 0x0080
        issue('{128'h80, 1'b0, 1'b1, 7'd8});
        chk("R6 zero fill", wide_res, 128'h0080);
        // R5 hand value: upper half picked
        issue('{{64'hAA, 64'h0}, 1'b1, 1'b1, 7'd8});
        chk("R5 upper half", wide_res, 128'h00AA);
        // R3 hand value: 16-bit lanes, shift 7
        issue('{128'h0000000000010001, 1'b0, 1'b1, 7'd23});
        chk("R3 16-bit shift", wide_res, 128'h00000080_00000080);

        // R10: idle cycles with new inputs must not change outputs
        @(negedge clk);
        src_vec  = {128{1'b1}};
        imm_code = 7'd64;
        zext     = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 hold result", wide_res, 128'h00000080_00000080);
        chk("R10 hold flag", {127'd0, bad_enc}, 128'd0);
        chk("R2 idle valid", {127'd0, out_valid}, 128'd0);

        // R1: reset after activity clears the outputs
        rst = 1'b1;
        @(negedge clk);
        chk("R1 re-reset", wide_res, 128'd0);
        rst = 1'b0;

        done = 1'b1;
        finish_run();
    end

endmodule